// File: doc/BRIEF.md
# Event Interrupt Status and Holdoff Unit

This unit gathers single-cycle event pulses from the engines of a network adapter into sticky status bits and raises one interrupt output while any pending bit is also enabled. Software reaches it through a small word-addressed register bus. Status can be read in two ways. The acknowledge view returns the pending bits and clears the bits it returned. The peek view returns the same bits and leaves them set.

A master control word holds the engine-enable levels, a transmit lock-mode flag and a stored three-bit interrupt line select. It also accepts two timed holdoff requests, a short one and a long one. While a holdoff window runs, the interrupt output is held low. A holdoff bit clears itself when its window ends. The window lengths scale with the parameter `TICKS_PER_US`, the number of clock cycles in one microsecond. A write of any value to word 0 returns the whole unit to its reset state.

Top module: `evt_irq_unit`

## Requirements
- R1: A read at word address 1 returns the pending status on `busRdata` in the same cycle, and every bit it returned is clear from the next clock edge on.
- R2: A read at word address 2 returns the same status value and clears no bit.
- R3: A pulse on `evtIn[i]` sets status bit i at the next edge, and the bit stays set until it is acknowledged. Bits 8:0 are statistics, line interface, service, TX DMA done, RX DMA done, DMA error, DMA length error, identifier mismatch and DMA overflow, in that order. Bits 16:9 are transmit channels 0 to 7.
- R4: The enable register at word address 3 is 17 bits wide and uses the status bit positions. Upper write bits are dropped and read back as 0. `irqOut` is 1 exactly when some status bit and its enable bit are both 1 and no holdoff window is running.
- R5: The master word at address 4 stores bit2 RX enable, bit3 TX enable, bit4 DMA enable, bit5 transmit lock mode (0 streaming, 1 lock) and bits 8:6 the interrupt select. These drive `rxEnable`, `txEnable`, `dmaEnable`, `txLockMode` and `irqSelect` and read back in place.
- R6: An event pulse in the same cycle as an acknowledge read that clears that bit leaves the bit set.
- R7: A write of any value to address 0 clears status, enable, the master word and any holdoff. An event in that same cycle is dropped. A read at address 0 returns `ID_VALUE`.
- R8: A master write with bit0 set and bit1 clear holds `irqOut` low for 500*`TICKS_PER_US` cycles after the write edge. A write with bit1 set holds it low for 1000*`TICKS_PER_US` cycles, whatever bit0 is.
- R9: Holdoff bits 1:0 read back as written while the window runs and read 0 from the edge where it ends. A master write with both bits 0 leaves a running window untouched.
- R10: Addresses 5 to 15 read 0, and writes to them, or to addresses 1 and 2, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtIn | input | 17 | Single-cycle event pulses, one per status bit |
| busAddr | input | 4 | Word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busRd is high, else 0 |
| irqOut | output | 1 | Interrupt request |
| rxEnable | output | 1 | RX engine enable |
| txEnable | output | 1 | TX engine enable |
| dmaEnable | output | 1 | DMA enable |
| txLockMode | output | 1 | Transmit lock mode |
| irqSelect | output | 3 | Stored interrupt line select |

## Verification
The bench sweeps every status bit through set, peek, acknowledge and enable gating, so a swapped or dead bit shows up in a wrong read value or a wrong interrupt level. It fires an event in the same cycle as an acknowledge of that bit; a design that lets the clear win would read 0 afterwards. It probes each holdoff window on the last suppressed cycle and on the first free cycle, which catches an off-by-one counter or a wrong long/short priority. It also checks that a plain master write does not cancel a running window. Unit reset, upper-bit masking of the enable register and writes to dead addresses are checked by reading back every register.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int GLB_EVTS = 9;

  typedef struct packed {
    logic softRst;
    logic ackRd;
    logic enWr;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    A_ID     = 4'h0,
    A_ACK    = 4'h1,
    A_PEEK   = 4'h2,
    A_ENABLE = 4'h3,
    A_MASTER = 4'h4
  } regAddr_e;
endpackage

// File: rtl/evt_irq_dp.sv
module evt_irq_dp
  import evt_irq_pkg::*;
#(
  parameter int N_EVT  = 17,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [N_EVT-1:0]  evtIn,
  input  logic [DATA_W-1:0] wdata,
  input  logic              holdActive,
  output logic [N_EVT-1:0]  statusQ,
  output logic [N_EVT-1:0]  enableQ,
  output logic              irqOut
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusQ[i] <= 1'b0;
        enableQ[i] <= 1'b0;
      end else if (strb.softRst) begin
        statusQ[i] <= 1'b0;
        enableQ[i] <= 1'b0;
      end else begin
        statusQ[i] <= evtIn[i] | (statusQ[i] & ~strb.ackRd);
        if (strb.enWr) enableQ[i] <= wdata[i];
      end
    end
  end

  logic anyPend;
  assign anyPend = |(statusQ & enableQ);
  assign irqOut  = anyPend & ~holdActive;

  // R1: bits returned by an acknowledge are gone unless re-set by an event
  a_r1_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackRd |=> (statusQ & $past(statusQ & ~evtIn)) == '0);

  // R6: an event is never lost, even against a clearing read
  a_r6_evt_not_lost: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtIn) && !strb.softRst) |=> ((statusQ & $past(evtIn)) == $past(evtIn)));

  // R7: unit reset empties status and enable
  a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (statusQ == '0 && enableQ == '0));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int          N_EVT        = 17,
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 4,
  parameter int          TICKS_PER_US = 200,
  parameter logic [31:0] ID_VALUE     = 32'h4000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [N_EVT-1:0]  statusQ,
  input  logic [N_EVT-1:0]  enableQ,
  output dpStrobe_t         strb,
  output logic              holdActive,
  output logic [DATA_W-1:0] busRdata,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              dmaEnable,
  output logic              txLockMode,
  output logic [2:0]        irqSelect
);

  localparam int SHORT_TICKS = 500 * TICKS_PER_US;
  localparam int LONG_TICKS  = 1000 * TICKS_PER_US;
  localparam int CNT_W       = $clog2(LONG_TICKS + 1);
  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_TICKS);

  logic wrId, wrMaster;
  assign wrId     = busWr && (busAddr == ADDR_W'(A_ID));
  assign wrMaster = busWr && (busAddr == ADDR_W'(A_MASTER));

  assign strb.softRst = wrId;
  assign strb.ackRd   = busRd && (busAddr == ADDR_W'(A_ACK));
  assign strb.enWr    = busWr && (busAddr == ADDR_W'(A_ENABLE));

  logic [6:0]       ctlBits;
  logic [1:0]       holdFlags;
  logic [CNT_W-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlBits   <= '0;
      holdFlags <= '0;
      holdCnt   <= '0;
    end else if (wrId) begin
      ctlBits   <= '0;
      holdFlags <= '0;
      holdCnt   <= '0;
    end else begin
      if (wrMaster) ctlBits <= busWdata[8:2];
      if (wrMaster && busWdata[1]) begin
        holdCnt   <= LONG_LD;
        holdFlags <= busWdata[1:0];
      end else if (wrMaster && busWdata[0]) begin
        holdCnt   <= SHORT_LD;
        holdFlags <= 2'b01;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
        if (holdCnt == CNT_W'(1)) holdFlags <= '0;
      end
    end
  end

  assign holdActive = (holdCnt != '0);
  assign rxEnable   = ctlBits[0];
  assign txEnable   = ctlBits[1];
  assign dmaEnable  = ctlBits[2];
  assign txLockMode = ctlBits[3];
  assign irqSelect  = ctlBits[6:4];

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        ADDR_W'(A_ID):     busRdata = DATA_W'(ID_VALUE);
        ADDR_W'(A_ACK),
        ADDR_W'(A_PEEK):   busRdata = DATA_W'(statusQ);
        ADDR_W'(A_ENABLE): busRdata = DATA_W'(enableQ);
        ADDR_W'(A_MASTER): busRdata = DATA_W'({ctlBits, holdFlags});
        default:           busRdata = '0;
      endcase
    end
  end

  // R9: a holdoff bit reads 1 only while its window counter runs
  a_r9_flags_track_window: assert property (@(posedge clk) disable iff (!rstN)
    (holdFlags != '0) |-> (holdCnt != '0));

  // R8: the window counter never exceeds the long window
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= LONG_LD);

  // R8: a running window only counts down unless reloaded by a hold write
  a_r8_count_down: assert property (@(posedge clk) disable iff (!rstN)
    ((holdCnt != '0) && !wrId && !(wrMaster && (busWdata[1:0] != 2'b00)))
      |=> (holdCnt == $past(holdCnt) - 1'b1));

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int          N_TXCH       = 8,
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 4,
  parameter int          TICKS_PER_US = 200,
  parameter logic [31:0] ID_VALUE     = 32'h4000_0001,
  localparam int         N_EVT        = GLB_EVTS + N_TXCH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_EVT-1:0]  evtIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              dmaEnable,
  output logic              txLockMode,
  output logic [2:0]        irqSelect
);

  dpStrobe_t        strb;
  logic             holdActive;
  logic [N_EVT-1:0] statusQ;
  logic [N_EVT-1:0] enableQ;

  evt_irq_ctrl #(
    .N_EVT(N_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .TICKS_PER_US(TICKS_PER_US), .ID_VALUE(ID_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .statusQ(statusQ), .enableQ(enableQ), .strb(strb),
    .holdActive(holdActive), .busRdata(busRdata), .rxEnable(rxEnable),
    .txEnable(txEnable), .dmaEnable(dmaEnable), .txLockMode(txLockMode),
    .irqSelect(irqSelect)
  );

  evt_irq_dp #(.N_EVT(N_EVT), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .evtIn(evtIn), .wdata(busWdata),
    .holdActive(holdActive), .statusQ(statusQ), .enableQ(enableQ),
    .irqOut(irqOut)
  );

endmodule

// File: tb/sim_evt_irq_unit.sv
`timescale 1ns/1ps
module sim_evt_irq_unit;
  localparam int NE = 17;
  localparam logic [31:0] IDV = 32'h4000_0001;
  localparam int SHORT = 500;
  localparam int LONG  = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NE-1:0] evtIn = '0;
  logic [3:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, rxEnable, txEnable, dmaEnable, txLockMode;
  logic [2:0] irqSelect;

  int checks = 0, failures = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  evt_irq_unit #(.TICKS_PER_US(1), .ID_VALUE(IDV)) u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
    .rxEnable(rxEnable), .txEnable(txEnable), .dmaEnable(dmaEnable),
    .txLockMode(txLockMode), .irqSelect(irqSelect)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start at a falling edge and end at the next one
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    busAddr = a; busRd = 1'b1;
    #0.5 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    evtIn = m;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // reset state
    chk("R4 reset irq", {31'b0, irqOut}, 32'h0);
    rd(4'h2, rv); chk("R2 reset status", rv, 32'h0);
    rd(4'h4, rv); chk("R5 reset master", rv, 32'h0);
    rd(4'h0, rv); chk("R7 id read", rv, IDV);

    // sweep every status bit
    for (int i = 0; i < NE; i++) begin
      wr(4'h3, 32'h1FFFF);
      pulse(NE'(1) << i);
      chk("R3 irq after event", {31'b0, irqOut}, 32'h1);
      rd(4'h2, rv); chk("R2 peek value", rv, 32'h1 << i);
      rd(4'h2, rv); chk("R2 peek keeps", rv, 32'h1 << i);
      wr(4'h3, ~(32'h1 << i));
      chk("R4 masked bit no irq", {31'b0, irqOut}, 32'h0);
      wr(4'h3, 32'h1 << i);
      chk("R4 own enable irq", {31'b0, irqOut}, 32'h1);
      rd(4'h1, rv); chk("R1 ack value", rv, 32'h1 << i);
      chk("R1 irq dropped", {31'b0, irqOut}, 32'h0);
      rd(4'h2, rv); chk("R1 cleared", rv, 32'h0);
    end

    // multiple sticky bits, partial re-set
    wr(4'h3, 32'h1FFFF);
    pulse(17'h00105);
    pulse(17'h10000);
    rd(4'h2, rv); chk("R3 sticky or", rv, 32'h10105);

    // R6: event meets acknowledge
    evtIn = 17'h00004;
    rd(4'h1, rv);
    evtIn = '0;
    chk("R6 ack return", rv, 32'h10105);
    rd(4'h2, rv); chk("R6 event kept", rv, 32'h00004);
    rd(4'h1, rv);

    // R4 upper bits
    wr(4'h3, 32'hFFFF_FFFF);
    rd(4'h3, rv); chk("R4 enable width", rv, 32'h1FFFF);

    // R5 master fields
    wr(4'h4, 32'h0000_01FC);
    chk("R5 outputs", {25'b0, irqSelect, txLockMode, dmaEnable, txEnable, rxEnable},
        32'h7F);
    rd(4'h4, rv); chk("R5 readback", rv, 32'h1FC);
    wr(4'h4, 32'h0000_0094);
    chk("R5 outputs two", {25'b0, irqSelect, txLockMode, dmaEnable, txEnable, rxEnable},
        32'h25);

    // R10 dead addresses and read-only views
    for (int a = 5; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      rd(4'(a), rv); chk("R10 dead read", rv, 32'h0);
    end
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h3, rv); chk("R10 enable untouched", rv, 32'h1FFFF);
    rd(4'h4, rv); chk("R10 master untouched", rv, 32'h094);
    rd(4'h2, rv); chk("R10 status untouched", rv, 32'h0);

    // R8 short window
    pulse(17'h00008);
    chk("R4 pending irq", {31'b0, irqOut}, 32'h1);
    wr(4'h4, 32'h1);
    chk("R8 short start low", {31'b0, irqOut}, 32'h0);
    repeat (SHORT - 1) @(negedge clk);
    chk("R8 short last low", {31'b0, irqOut}, 32'h0);
    rd(4'h4, rv); chk("R9 short flag set", rv, 32'h1);
    chk("R8 short end high", {31'b0, irqOut}, 32'h1);
    rd(4'h4, rv); chk("R9 short flag clear", rv, 32'h0);

    // R8 long window, both bits: long wins
    wr(4'h4, 32'h3);
    repeat (LONG - 1) @(negedge clk);
    chk("R8 long last low", {31'b0, irqOut}, 32'h0);
    rd(4'h4, rv); chk("R9 both flags set", rv, 32'h3);
    chk("R8 long end high", {31'b0, irqOut}, 32'h1);
    rd(4'h4, rv); chk("R9 both flags clear", rv, 32'h0);

    // R9 plain write does not cancel
    wr(4'h4, 32'h1);
    wr(4'h4, 32'h4);
    repeat (SHORT - 2) @(negedge clk);
    chk("R9 window kept", {31'b0, irqOut}, 32'h0);
    @(negedge clk);
    chk("R9 window ends", {31'b0, irqOut}, 32'h1);
    chk("R9 rx enable", {31'b0, rxEnable}, 32'h1);

    // R7 unit reset with event dropped
    wr(4'h4, 32'h1FE);
    evtIn = 17'h00001;
    wr(4'h0, 32'h0);
    evtIn = '0;
    rd(4'h2, rv); chk("R7 status cleared", rv, 32'h0);
    rd(4'h3, rv); chk("R7 enable cleared", rv, 32'h0);
    rd(4'h4, rv); chk("R7 master cleared", rv, 32'h0);
    chk("R7 outputs cleared", {26'b0, irqSelect, txLockMode, dmaEnable, txEnable, irqOut},
        32'h0);
    wr(4'h3, 32'h1);
    pulse(17'h1);
    chk("R7 no holdoff left", {31'b0, irqOut}, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule